// File: doc/BRIEF.md
# UART Transmitter with Stop Guard

This block is the transmit half of a UART channel. Software places a 7-bit character in the block, chooses whether a parity bit goes with it, and fires a one-cycle start strobe. The block then walks an internal slot counter from a programmable first slot to a programmable last slot, holding each slot on the serial line for a programmable number of clock cycles. The usual setting sends slots 0 to 9. Slot 0 is the start bit. Slots 1 to 7 carry the data, least significant bit first. Slot 8 is either a stop bit or an even-parity bit. Slot 9 and every slot above it are driven high.

When the last slot has been held for its full width, the busy flag drops and a completion interrupt pulses for one cycle. That interrupt line is shared: the receiver's completion pulse is ORed onto it, so the two channels can run at the same time.

A new start strobe that arrives just after completion must not shorten the final high slot. For one bit period after busy falls, the block sits in a guard interval. A strobe that arrives during the guard is remembered and launches the next frame as soon as the guard ends. A strobe that arrives while a frame is in progress is dropped.

Top module: `uart_tx_guard`

## Requirements
- R1: Whenever `busy_o` is low (idle, guard interval, and during reset), `txd_o` is 1.
- R2: Slot k for k = 1..7 drives data bit k-1 of the character, so the character goes out least significant bit first.
- R3: Slot 0 drives 0 (the start bit).
- R4: Slot 8 drives 1 when `parity_en_i` is 0. When `parity_en_i` is 1, slot 8 drives the XOR of the seven data bits, which gives even parity over data and parity.
- R5: Slot 9 and every slot above it (up to 15) drive 1.
- R6: A frame sends the slots from `slot_first_i` through `slot_last_i` inclusive, in increasing order. Each slot lasts `bit_div_i`+1 clock cycles. Frame data and settings are captured when the frame is launched.
- R7: `busy_o` is high from the cycle after an accepted start strobe until the last slot ends. In the cycle where it falls, `irq_o` is 1 for exactly one cycle.
- R8: `irq_o` is also 1 in every cycle in which `rx_done_i` is 1, whatever the transmit state.
- R9: A start strobe that arrives while `busy_o` is high is ignored. No extra frame follows the current one.
- R10: For `bit_div_i`+1 cycles after `busy_o` falls (the guard), no frame starts. A strobe received during the guard is held, and `busy_o` rises exactly `bit_div_i`+1 cycles after it fell.
- R11: A strobe received while idle and outside the guard raises `busy_o` in the next cycle, with the line already driving slot `slot_first_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle transmit start strobe |
| data_i | input | DATA_W (7) | Character to send |
| parity_en_i | input | 1 | 1: slot 8 carries even parity; 0: slot 8 is a stop bit |
| slot_first_i | input | SLOT_W (4) | First slot of the frame |
| slot_last_i | input | SLOT_W (4) | Last slot of the frame (must not be below the first slot) |
| bit_div_i | input | DIV_W (8) | Slot width minus one, in clock cycles |
| rx_done_i | input | 1 | Receiver completion pulse, merged into the interrupt |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |
| irq_o | output | 1 | Shared completion interrupt pulse |

## Verification
The hardest situation to reach is a start strobe that lands inside the guard interval. That window opens only on the cycle after a frame ends and lasts one slot width. The bench counts falling clock edges from the launch of each frame and computes the completion cycle from the slot count and the divider. It fires a second strobe on the first guard cycle and checks that busy stays low through the last guard cycle and rises exactly one slot width after completion. It also fires a strobe in the middle of a frame and checks that nothing follows the guard.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_GUARD = 2'd2
  } tx_state_e;
endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
  parameter int DATA_W = 7,
  parameter int SLOT_W = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              parity_en_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              bit_o
);
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int GUARDS = DATA_W + 1;

  logic [NSLOT-1:0] frame;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k == 0) begin : g_start
      assign frame[k] = 1'b0;
    end else if (k <= DATA_W) begin : g_data
      assign frame[k] = data_i[k-1];
    end else if (k == GUARDS) begin : g_par
      assign frame[k] = parity_en_i ? ^data_i : 1'b1;
    end else begin : g_high
      assign frame[k] = 1'b1;
    end
  end

  assign bit_o = frame[slot_i];
endmodule

// File: rtl/uart_tx_guard.sv
module uart_tx_guard
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 7,
  parameter int SLOT_W = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              parity_en_i,
  input  logic [SLOT_W-1:0] slot_first_i,
  input  logic [SLOT_W-1:0] slot_last_i,
  input  logic [DIV_W-1:0]  bit_div_i,
  input  logic              rx_done_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              irq_o
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  tx_state_e         st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d, last_q, last_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              par_q, par_d;
  logic              pend_q, pend_d;
  logic              done_q, done_d;
  logic              tick, load, slot_bit;

  uart_tx_bit_timer #(.DIV_W(DIV_W)) i_timer (
    .clk    (clk),
    .rst_n  (arst_n),
    .run_i  (st_q != TX_IDLE),
    .div_i  (div_q),
    .tick_o (tick)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_frame (
    .data_i      (data_q),
    .parity_en_i (par_q),
    .slot_i      (slot_q),
    .bit_o       (slot_bit)
  );

  // a frame launches from idle, or from an expiring guard with a held strobe
  assign load = ((st_q == TX_IDLE) && start_i) ||
                ((st_q == TX_GUARD) && tick && (pend_q || start_i));

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    last_d = last_q;
    data_d = data_q;
    div_d  = div_q;
    par_d  = par_q;
    pend_d = pend_q;
    done_d = 1'b0;
    if (load) begin
      st_d   = TX_SEND;
      slot_d = slot_first_i;
      last_d = slot_last_i;
      data_d = data_i;
      div_d  = bit_div_i;
      par_d  = parity_en_i;
      pend_d = 1'b0;
    end else begin
      unique case (st_q)
        TX_SEND: begin
          if (tick) begin
            if (slot_q == last_q) begin
              st_d   = TX_GUARD;
              done_d = 1'b1;
            end else begin
              slot_d = slot_q + 1'b1;
            end
          end
        end
        TX_GUARD: begin
          if (tick) begin
            st_d   = TX_IDLE;
            pend_d = 1'b0;
          end else if (start_i) begin
            pend_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= TX_IDLE;
      slot_q <= '0;
      last_q <= '0;
      data_q <= '0;
      div_q  <= '0;
      par_q  <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      last_q <= last_d;
      data_q <= data_d;
      div_q  <= div_d;
      par_q  <= par_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  assign busy_o = (st_q == TX_SEND);
  assign txd_o  = busy_o ? slot_bit : 1'b1;
  assign irq_o  = done_q | rx_done_i;
endmodule

// File: rtl/uart_tx_guard_chk.sv
module uart_tx_guard_chk #(
  parameter int SLOT_W = 4,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_done_i,
  input logic [SLOT_W-1:0] slot_first_i,
  input logic              txd_o,
  input logic              busy_o,
  input logic              irq_o,
  input logic [DIV_W-1:0]  div_q
);
  logic [DIV_W:0] gap_q;
  logic           seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_q | busy_o;
      if (busy_o)          gap_q <= '0;
      else if (!(&gap_q))  gap_q <= gap_q + 1'b1;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> txd_o);  // R1

  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) && ($past(slot_first_i) == '0) |-> !txd_o);  // R3

  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> irq_o);  // R7

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !rx_done_i |-> $fell(busy_o));  // R8

  AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) && seen_q |-> gap_q >= ({1'b0, $past(div_q)} + 1'b1));  // R10
endmodule

bind uart_tx_guard uart_tx_guard_chk #(.SLOT_W(SLOT_W), .DIV_W(DIV_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_done_i    (rx_done_i),
  .slot_first_i (slot_first_i),
  .txd_o        (txd_o),
  .busy_o       (busy_o),
  .irq_o        (irq_o),
  .div_q        (div_q)
);

// File: tb/test_uart_tx_guard.sv
module test_uart_tx_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {data[39:33], parity[32], first[31:28], last[27:24], div[23:16], frame[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {7'h55, 1'b0, 4'd0, 4'd9,  8'd3, 16'hFFAA},
    {7'h2C, 1'b1, 4'd0, 4'd9,  8'd1, 16'hFF58},
    {7'h33, 1'b1, 4'd0, 4'd8,  8'd0, 16'hFE66},
    {7'h7F, 1'b1, 4'd2, 4'd5,  8'd2, 16'hFFFE},
    {7'h01, 1'b0, 4'd0, 4'd12, 8'd1, 16'hFF02}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, parity_en_i, rx_done_i;
  logic [6:0] data_i;
  logic [3:0] slot_first_i, slot_last_i;
  logic [7:0] bit_div_i;
  logic       txd_o, busy_o, irq_o;
  int         tests = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_guard i_uart_tx_guard (
    .clk, .rst_n, .start_i, .data_i, .parity_en_i, .slot_first_i,
    .slot_last_i, .bit_div_i, .rx_done_i, .txd_o, .busy_o, .irq_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // mode 0: plain; 1: strobe while busy (R9); 2: strobe in first guard cycle (R10)
  task automatic run_frame(input logic [39:0] v, input int mode);
    int p, ns, first, total;
    string tag;
    p     = int'(v[23:16]) + 1;
    first = int'(v[31:28]);
    ns    = int'(v[27:24]) - first + 1;
    total = (ns + 1) * p + 2;
    data_i = v[39:33]; parity_en_i = v[32];
    slot_first_i = v[31:28]; slot_last_i = v[27:24]; bit_div_i = v[23:16];
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int n = 0; n < total; n++) begin
      if (n < ns * p) begin
        int s;
        s = first + n / p;
        if (s == 0) tag = "R3 start slot";
        else if (s <= 7) tag = "R2 data slot";
        else if (s == 8) tag = "R4 slot 8";
        else tag = "R5 high slot";
        if (n % p == 0 || n % p == p - 1) chk(tag, txd_o, v[s]);
        if (n == 0) chk("R11 busy after strobe", busy_o, 1'b1);
        if (n == ns * p - 1) chk("R6 busy to last slot end", busy_o, 1'b1);
      end else if (n == ns * p) begin
        chk("R7 busy falls", busy_o, 1'b0);
        chk("R7 irq pulse", irq_o, 1'b1);
        chk("R1 line high in guard", txd_o, 1'b1);
      end else if (n == ns * p + 1) begin
        chk("R7 irq one cycle", irq_o, 1'b0);
      end
      if (mode == 2 && n == (ns + 1) * p - 1) chk("R10 held in guard", busy_o, 1'b0);
      if (mode == 2 && n == (ns + 1) * p) begin
        chk("R10 pended launch busy", busy_o, 1'b1);
        chk("R10 pended launch start bit", txd_o, 1'b0);
      end
      if (mode == 1 && n == (ns + 1) * p + 1) begin
        chk("R9 strobe while busy ignored", busy_o, 1'b0);
        chk("R9 line stays idle", txd_o, 1'b1);
      end
      start_i = ((mode == 1 && n == p) || (mode == 2 && n == ns * p)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (mode == 2) repeat ((ns + 3) * p) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rx_done_i = 1'b0; data_i = '0;
    parity_en_i = 1'b0; slot_first_i = 4'd0; slot_last_i = 4'd9; bit_div_i = 8'd3;
    repeat (3) @(negedge clk);
    chk("R1 reset line high", txd_o, 1'b1);
    chk("R7 reset not busy", busy_o, 1'b0);
    chk("R8 reset irq low", irq_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i], 0);
      repeat (3) @(negedge clk);
    end

    run_frame(VEC[0], 1);
    repeat (3) @(negedge clk);
    run_frame(VEC[0], 2);
    repeat (3) @(negedge clk);

    // shared interrupt from the receiver
    rx_done_i = 1'b1;
    #(CLK_PERIOD/4);
    chk("R8 rx completion on irq", irq_o, 1'b1);
    chk("R8 tx stays idle", busy_o, 1'b0);
    @(negedge clk) rx_done_i = 1'b0;
    #(CLK_PERIOD/4);
    chk("R8 irq clears", irq_o, 1'b0);

    // reset in the middle of a frame returns the line high
    data_i = 7'h00; parity_en_i = 1'b0; slot_first_i = 4'd0; slot_last_i = 4'd9;
    bit_div_i = 8'd5;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2 zero data mid frame", txd_o, 1'b0);
    rst_n = 1'b0;
    #(CLK_PERIOD/4);
    chk("R1 line high on reset", txd_o, 1'b1);
    chk("R7 busy cleared on reset", busy_o, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule